// File: doc/BRIEF.md
# Serial switch-matrix control register

This block is the receiving end of a three-wire serial control port for a bank of eight analog switches. A host lowers an active-low frame select and clocks serial data in, most significant bit first, one bit on each falling edge of the serial clock. When the host raises the frame select, the eight bits held in the shift register are copied into a switch-enable register. Each bit of that register closes (1) or opens (0) one switch. Any mix of switches may be closed, including all of them or none.

A serial output presents the bit leaving the top of the shift register on each rising serial-clock edge. This output feeds the data input of a following device in a chain, or lets the host read back the shift-register contents. The serial pins are not treated as clocks. The whole block runs on a system clock at least four times faster than the serial clock. The serial clock, frame select and data pass through two-flop synchronisers, and their edges are detected in the system clock domain. An active-low asynchronous reset clears every register.

Top module: `swm_serial_port`

## Requirements
- R1: While the frame select is low, each falling serial-clock edge shifts the data input into bit 0 of the 8-bit shift register and moves the older bits up one place, so the first bit sent ends in bit 7. Shift-register bit i drives switch i+1 once committed (bit 0 is switch 1, bit 7 is switch 8). A 1 closes the switch.
- R2: While the frame select is high, activity on the serial clock and data input changes neither the shift register nor the serial output.
- R3: The switch-enable register changes only on a rising edge of the frame select, and takes the shift-register contents present at that edge. Mid-frame it keeps its previous value.
- R4: A frame longer than eight clocks commits the last eight bits shifted in.
- R5: A frame shorter than eight clocks commits the eight most recent bits: the new bits plus the lower bits of the earlier contents, moved up.
- R6: On each rising serial-clock edge while the frame select is low, the serial output takes shift-register bit 7. A bit shifted in therefore appears on the output eight clocks later, and the first eight clocks of a frame read back the previous contents, MSB first.
- R7: While reset is low, the shift register, the switch-enable register and the serial output are all zero.
- R8: After reset, the switch-enable register stays zero until a complete frame ends. A frame cut short by reset commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low frame select |
| serClk | input | 1 | Serial clock; data captured on its falling edge |
| serIn | input | 1 | Serial data input, MSB first |
| serOut | output | 1 | Serial data output for chaining or readback |
| swEn | output | 8 | Switch-enable word, bit i closes switch i+1 |

## Verification
The main function is driven through a table of frames of eight, sixteen and three clocks, with words chosen to tell the cases apart:
- Patterns such as A5, 81, all ones and all zeros expose a reversed bit order or a stuck bit.
- A sixteen-clock frame shows that only the last byte is kept.
- A three-clock frame sent after a known word shows that older bits are moved up rather than cleared.

The serial output is compared over a sixteen-clock frame against the previous word followed by the new bits, which fixes both the eight-clock delay and the edge it changes on. Other directed frames cover these cases:
- Serial toggling while the frame is closed.
- The switch word checked in the middle of a frame.
- A frame aborted by reset.

// File: rtl/swm_pkg.sv
package swm_pkg;

  // Strobes from the control path to the datapath, one system clock wide.
  typedef struct packed {
    logic shiftEn;   // falling serial clock inside a frame
    logic outEn;     // rising serial clock inside a frame
    logic commit;    // frame select has just gone high
  } swmStrobe_t;

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{INIT}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
  import swm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       selN,
  input  logic       serClk,
  input  logic       serIn,
  output swmStrobe_t strb,
  output logic       dataBit
);

  logic clkS, selS, datS;
  logic clkPrev, selPrev;

  // The idle select level is high, so a reset never looks like a frame end.
  swm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_syncClk (
    .clk(clk), .rst_n(rst_n), .d(serClk), .q(clkS));
  swm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_syncSel (
    .clk(clk), .rst_n(rst_n), .d(selN), .q(selS));
  swm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_syncDat (
    .clk(clk), .rst_n(rst_n), .d(serIn), .q(datS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      clkPrev <= clkS;
      selPrev <= selS;
    end
  end

  always_comb begin
    strb.shiftEn = clkPrev & ~clkS & ~selS;
    strb.outEn   = ~clkPrev & clkS & ~selS;
    strb.commit  = ~selPrev & selS;
  end

  // Data takes the same synchroniser depth as the clock, so it lines up with the edge.
  assign dataBit = datS;

endmodule

// File: rtl/swm_dpath.sv
module swm_dpath
  import swm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  swmStrobe_t       strb,
  input  logic             dataBit,
  output logic [WIDTH-1:0] shiftWord,
  output logic             serOut,
  output logic [WIDTH-1:0] swEn
);

  localparam int MSB = WIDTH - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftWord <= '0;
      serOut    <= 1'b0;
      swEn      <= '0;
    end else begin
      if (strb.shiftEn) shiftWord <= {shiftWord[MSB-1:0], dataBit};
      if (strb.outEn)   serOut    <= shiftWord[MSB];
      if (strb.commit)  swEn      <= shiftWord;
    end
  end

endmodule

// File: rtl/swm_serial_port.sv
module swm_serial_port
  import swm_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selN,
  input  logic             serClk,
  input  logic             serIn,
  output logic             serOut,
  output logic [WIDTH-1:0] swEn
);

  swmStrobe_t       strb;
  logic             dataBit;
  logic [WIDTH-1:0] shiftWord;

  swm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .selN(selN), .serClk(serClk), .serIn(serIn),
    .strb(strb), .dataBit(dataBit));

  swm_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dataBit(dataBit),
    .shiftWord(shiftWord), .serOut(serOut), .swEn(swEn));

endmodule

// File: rtl/swm_checker.sv
module swm_checker
  import swm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             selN,
  input logic             serOut,
  input logic [WIDTH-1:0] swEn,
  input swmStrobe_t       strb,
  input logic [WIDTH-1:0] shiftWord
);

  // R1: at most one strobe per system clock
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.shiftEn, strb.outEn, strb.commit}));

  // R2: a shift happens only if the select pin was low two clocks earlier
  p_shift_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftEn |-> !$past(selN, 2));

  // R2: without a shift strobe the shift register holds
  p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> $stable(shiftWord));

  // R3: the switch word moves only after a commit strobe
  p_sw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (swEn != $past(swEn)) |-> $past(strb.commit));

  // R3: a commit loads the shift-register contents
  p_commit_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> (swEn == $past(shiftWord)));

  // R6: the serial output moves only on a rising serial clock
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.outEn |=> $stable(serOut));

  // R7: outputs held at zero during reset
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_zero_r7: assert (swEn == '0 && serOut == 1'b0);
    end
  end

endmodule

bind swm_serial_port swm_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .selN(selN), .serOut(serOut), .swEn(swEn),
  .strb(strb), .shiftWord(shiftWord));

// File: tb/swm_serial_port_bench.sv
module swm_serial_port_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       selN;
  logic       serClk;
  logic       serIn;
  logic       serOut;
  logic [7:0] swEn;

  int          total = 0;
  int          bad   = 0;
  logic [31:0] seenOut = '0;
  logic        outBefore;

  always #2.5 clk = ~clk;

  swm_serial_port u_swm_serial_port (
    .clk(clk), .rst_n(rst_n), .selN(selN), .serClk(serClk), .serIn(serIn),
    .serOut(serOut), .swEn(swEn));

  // Each entry: [31:16] bits sent (LSB last), [15:8] bit count, [7:0] expected switch word.
  localparam logic [31:0] VEC [7] = '{
    32'h00A5_08_A5, 32'h00FF_08_FF, 32'h0000_08_00, 32'h0081_08_81,
    32'h12C3_10_C3, 32'h0005_03_1D, 32'h003C_08_3C };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // The serial clock half period is four system clocks. Output is recorded after each rise.
  task automatic shiftBits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serIn  = bits[i];
      serClk = 1'b1;
      tick(4);
      seenOut = {seenOut[30:0], serOut};
      serClk = 1'b0;
      tick(4);
    end
  endtask

  task automatic openFrame();
    selN = 1'b0;
    tick(4);
  endtask

  task automatic closeFrame();
    selN = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] prevWord;
    rst_n = 1'b0; selN = 1'b1; serClk = 1'b0; serIn = 1'b0;
    tick(5);
    check("R7 reset swEn", {8'h0, swEn}, 16'h0);
    check("R7 reset serOut", {15'h0, serOut}, 16'h0);
    rst_n = 1'b1;
    tick(6);
    check("R8 idle after reset", {8'h0, swEn}, 16'h0);

    // Table of frames: R1 bit order, R4 long frame, R5 short frame, R3 mid-frame hold.
    prevWord = 8'h00;
    for (int v = 0; v < 7; v++) begin
      openFrame();
      shiftBits(VEC[v][31:16], int'(VEC[v][15:8]));
      check("R3 hold mid-frame", {8'h0, swEn}, {8'h0, prevWord});
      closeFrame();
      check("R1/R4/R5 commit", {8'h0, swEn}, {8'h0, VEC[v][7:0]});
      prevWord = VEC[v][7:0];
    end

    // R6: readback of 3C, then the new bits delayed by eight clocks. R4: last byte is 2E.
    openFrame();
    shiftBits(16'hB72E, 16);
    closeFrame();
    check("R6 serial out stream", seenOut[15:0], 16'h3CB7);
    check("R4 sixteen-clock frame", {8'h0, swEn}, 16'h002E);

    // R2: serial activity with the frame closed is ignored.
    outBefore = serOut;
    for (int k = 0; k < 10; k++) begin
      serIn  = k[0];
      serClk = 1'b1;
      tick(4);
      serClk = 1'b0;
      tick(4);
    end
    check("R2 serOut held", {15'h0, serOut}, {15'h0, outBefore});
    check("R2 swEn held", {8'h0, swEn}, 16'h002E);
    openFrame();
    shiftBits(16'h005A, 8);
    closeFrame();
    check("R2 shift register intact", {8'h0, seenOut[7:0]}, 16'h002E);
    check("R1 commit 5A", {8'h0, swEn}, 16'h005A);

    // R7/R8: frame aborted by reset.
    openFrame();
    shiftBits(16'h001F, 5);
    rst_n = 1'b0;
    tick(2);
    check("R7 swEn cleared", {8'h0, swEn}, 16'h0);
    check("R7 serOut cleared", {15'h0, serOut}, 16'h0);
    selN = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(8);
    check("R8 aborted frame not committed", {8'h0, swEn}, 16'h0);
    openFrame();
    shiftBits(16'h0000, 8);
    closeFrame();
    check("R7 shift register cleared", {8'h0, seenOut[7:0]}, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule